// File: doc/BRIEF.md
# Interrupt Priority Level Gate

This block holds the processor's current interrupt priority: a three-bit level field and, above it, a trap-in-progress bit. Together they form a four-bit priority. In every cycle it decides whether an incoming interrupt request may be taken. A request is taken only when its level is strictly above the current level field and no trap is underway. When a request is taken, the level field rises to that request's level on the next clock edge.

A trap-entry strobe sets the trap bit. Software can rewrite the level field, and it can clear the trap bit, but it can never set the trap bit. On exception entry the surrounding core saves the four-bit priority shown on a dedicated output. On exception return the core hands the saved value back through a restore port, and the block reloads both fields from it. The block does not fetch vectors, arbitrate between sources or hold the stack.

Top module: `prio_gate`

## Requirements
- R1: After reset the level field is 0, the trap bit is 0 and `accept` is 0.
- R2: `accept` is high in the same cycle only when `req_valid` is 1, the trap bit is 0 and `req_level` is greater than the current level field. A request with `req_valid` at 0 is never accepted.
- R3: With the level field at 7, no request is accepted.
- R4: While the trap bit is 1, no request of any level is accepted, whatever the level field holds.
- R5: On the edge that ends a cycle with `accept` high, the level field is loaded with that request's level. Without an accept, restore or write, the level field keeps its value.
- R6: A `trap_enter` pulse sets the trap bit on the next edge. It wins over a software clear in the same cycle and over a restore in the same cycle.
- R7: A software write (`sw_wr_en`) loads `sw_wr_data[2:0]` into the level field. Bit 3 of the write clears the trap bit when it is 0. When bit 3 is 1 the trap bit is left unchanged, so a write never sets it.
- R8: `save_level` shows, in the same cycle, the current priority with the trap bit in bit 3 and the level field in bits 2:0.
- R9: A restore (`rti_valid`) loads bit 3 of `rti_level` into the trap bit and bits 2:0 into the level field on the next edge. For the level field, a restore wins over an accept and over a software write in the same cycle.
- R10: When an accept and a software write fall in the same cycle, the accepted request's level wins for the level field.
- R11: A request of level 0 is never accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An interrupt request is pending |
| req_level | input | 3 | Level of the pending request |
| trap_enter | input | 1 | Trap-entry strobe; sets the trap bit |
| sw_wr_en | input | 1 | Software write to the priority field |
| sw_wr_data | input | 4 | Write data: bit 3 = 0 clears the trap bit, bits 2:0 = new level |
| rti_valid | input | 1 | Exception-return restore strobe |
| rti_level | input | 4 | Popped priority: bit 3 = trap bit, bits 2:0 = level |
| accept | output | 1 | The request is accepted this cycle |
| cur_level | output | 3 | Current level field |
| trap_active | output | 1 | Trap bit (priority is 8 or above) |
| save_level | output | 4 | Priority to push on exception entry |

## Verification
`accept` and `save_level` are combinational, so they are due in the cycle the request or state is presented. The bench drives inputs just after a rising edge and reads these outputs a few nanoseconds later, before the next edge. `cur_level` and `trap_active` change one edge after an accept, trap strobe, write or restore. The bench clocks once and reads them just after that edge, and it drops the stimulus before the edge that follows. Same-cycle collisions (trap against clear, restore against accept, accept against write) are each driven in a single cycle, and the winner is checked after the next edge.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int LVL_W  = 3;
  localparam int PRIO_W = LVL_W + 1;

  typedef struct packed {
    logic             trap;
    logic [LVL_W-1:0] lvl;
  } prio_t;

  // A request passes when it is valid, no trap is underway, and it is
  // strictly above the held level. Level 0 can never exceed anything.
  function automatic logic may_accept(input logic valid,
                                      input logic [LVL_W-1:0] req,
                                      input prio_t cur);
    return valid && !cur.trap && (req > cur.lvl);
  endfunction

  // Next level field: restore beats accept, accept beats a write.
  function automatic logic [LVL_W-1:0] next_lvl(input prio_t cur,
                                                input logic acc,
                                                input logic [LVL_W-1:0] req,
                                                input logic wr,
                                                input prio_t wr_val,
                                                input logic rti,
                                                input prio_t rti_val);
    if (rti)      return rti_val.lvl;
    else if (acc) return req;
    else if (wr)  return wr_val.lvl;
    else          return cur.lvl;
  endfunction

  // Next trap bit: entry beats restore, restore beats a write.
  // A write can only clear the bit.
  function automatic logic next_trap(input prio_t cur,
                                     input logic enter,
                                     input logic wr,
                                     input prio_t wr_val,
                                     input logic rti,
                                     input prio_t rti_val);
    if (enter)                  return 1'b1;
    else if (rti)               return rti_val.trap;
    else if (wr && !wr_val.trap) return 1'b0;
    else                        return cur.trap;
  endfunction
endpackage

// File: rtl/prio_accept.sv
module prio_accept
  import prio_pkg::*;
(
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  prio_t            cur,
  output logic             accept
);
  assign accept = may_accept(req_valid, req_level, cur);
endmodule

// File: rtl/prio_state.sv
module prio_state
  import prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [LVL_W-1:0] req_level,
  input  logic             trap_enter,
  input  logic             sw_wr_en,
  input  prio_t            sw_val,
  input  logic             rti_valid,
  input  prio_t            rti_val,
  output prio_t            cur
);
  prio_t nxt;
  logic  lvl_raise;
  logic  trap_cleared;

  assign lvl_raise    = acc && !rti_valid;
  assign trap_cleared = cur.trap && !trap_enter && !rti_valid &&
                        sw_wr_en && !sw_val.trap;

  always_comb begin
    nxt.lvl  = next_lvl(cur, acc, req_level, sw_wr_en, sw_val, rti_valid, rti_val);
    nxt.trap = next_trap(cur, trap_enter, sw_wr_en, sw_val, rti_valid, rti_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  // R5: an accepted level lands one edge later
  p_raise_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_raise |=> cur.lvl == $past(req_level));

  // R6: trap entry always sets the bit
  p_trap_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> cur.trap);

  // R7: nothing but entry or a restore can set the trap bit
  p_no_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur.trap && !trap_enter && !(rti_valid && rti_val.trap)) |=> !cur.trap);

  // R7: a clearing write without competition leaves the bit low
  p_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cleared |=> !cur.trap);

  // R9: a restore reloads both fields
  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_valid && !trap_enter) |=> cur == $past(rti_val));
endmodule

// File: rtl/prio_gate.sv
module prio_gate
  import prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LVL_W-1:0]  req_level,
  input  logic              trap_enter,
  input  logic              sw_wr_en,
  input  logic [PRIO_W-1:0] sw_wr_data,
  input  logic              rti_valid,
  input  logic [PRIO_W-1:0] rti_level,
  output logic              accept,
  output logic [LVL_W-1:0]  cur_level,
  output logic              trap_active,
  output logic [PRIO_W-1:0] save_level
);
  prio_t cur;
  prio_t sw_val;
  prio_t rti_val;
  logic  acc;

  assign sw_val  = sw_wr_data;
  assign rti_val = rti_level;

  prio_accept u_accept (
    .req_valid (req_valid),
    .req_level (req_level),
    .cur       (cur),
    .accept    (acc)
  );

  prio_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .req_level  (req_level),
    .trap_enter (trap_enter),
    .sw_wr_en   (sw_wr_en),
    .sw_val     (sw_val),
    .rti_valid  (rti_valid),
    .rti_val    (rti_val),
    .cur        (cur)
  );

  assign accept      = acc;
  assign cur_level   = cur.lvl;
  assign trap_active = cur.trap;
  assign save_level  = cur;

  // R4: a trap masks every request
  p_trap_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_active |-> !accept);

  // R11: level 0 never passes
  p_zero_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_level == '0) |-> !accept);

  // R3: the top level blocks everything
  p_top_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&cur_level) |-> !accept);

  // R2: an accepted request is valid and above the held level
  p_accept_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (req_valid && req_level > cur_level));
endmodule

// File: tb/prio_gate_test.sv
module prio_gate_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_level;
  logic       trap_enter;
  logic       sw_wr_en;
  logic [3:0] sw_wr_data;
  logic       rti_valid;
  logic [3:0] rti_level;
  logic       accept;
  logic [2:0] cur_level;
  logic       trap_active;
  logic [3:0] save_level;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prio_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .trap_enter(trap_enter), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .rti_valid(rti_valid), .rti_level(rti_level), .accept(accept),
    .cur_level(cur_level), .trap_active(trap_active), .save_level(save_level)
  );

  // entry: {held level[2:0], trap, request level[2:0], valid}
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    {3'd0, 1'b0, 3'd0, 1'b1},  // R11 level 0
    {3'd0, 1'b0, 3'd1, 1'b1},
    {3'd0, 1'b0, 3'd7, 1'b1},
    {3'd3, 1'b0, 3'd3, 1'b1},  // equal level
    {3'd3, 1'b0, 3'd4, 1'b1},
    {3'd6, 1'b0, 3'd7, 1'b1},
    {3'd7, 1'b0, 3'd7, 1'b1},  // R3
    {3'd0, 1'b1, 3'd7, 1'b1},  // R4
    {3'd2, 1'b1, 3'd5, 1'b1},  // R4
    {3'd5, 1'b0, 3'd2, 1'b1},
    {3'd1, 1'b0, 3'd6, 1'b0},  // not valid
    {3'd4, 1'b0, 3'd0, 1'b1}   // R11
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_level = 0; trap_enter = 0; sw_wr_en = 0;
    sw_wr_data = 0; rti_valid = 0; rti_level = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    tick(); tick();
    check("R1 level", cur_level, 0);
    check("R1 trap", trap_active, 0);
    check("R1 accept", accept, 0);
    rst_n = 1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [2:0] hl, rl;
      logic tr, vl, exp_acc;
      {hl, tr, rl, vl} = VEC[i];
      exp_acc = vl && !tr && (rl > hl);
      sw_wr_en = 1; sw_wr_data = {1'b0, hl};
      tick();
      idle();
      if (tr) begin
        trap_enter = 1; tick(); idle();
      end
      req_valid = vl; req_level = rl;
      #2;
      check("R2 accept", accept, exp_acc);
      check("R8 save", save_level, {tr, hl});
      tick();
      idle();
      check("R5 level", cur_level, exp_acc ? rl : hl);
    end

    // R6: trap entry beats a clearing write
    sw_wr_en = 1; sw_wr_data = 4'b0011; tick(); idle();
    trap_enter = 1; sw_wr_en = 1; sw_wr_data = 4'b0010; tick(); idle();
    check("R6 trap over clear", trap_active, 1);
    check("R7 write level", cur_level, 2);

    // R7: bit 3 = 1 keeps trap set; bit 3 = 0 clears it
    sw_wr_en = 1; sw_wr_data = 4'b1101; tick(); idle();
    check("R7 keep trap", trap_active, 1);
    check("R7 level", cur_level, 5);
    sw_wr_en = 1; sw_wr_data = 4'b0101; tick(); idle();
    check("R7 clear trap", trap_active, 0);
    // R7: a write with bit 3 = 1 cannot set the trap bit
    sw_wr_en = 1; sw_wr_data = 4'b1001; tick(); idle();
    check("R7 no set", trap_active, 0);
    check("R8 save after write", save_level, 4'b0001);

    // R10: accept beats a write
    sw_wr_en = 1; sw_wr_data = 4'b0010; tick(); idle();
    req_valid = 1; req_level = 5; sw_wr_en = 1; sw_wr_data = 4'b0001;
    #2 check("R10 accept", accept, 1);
    tick(); idle();
    check("R10 level", cur_level, 5);

    // R9: restore beats an accept
    sw_wr_en = 1; sw_wr_data = 4'b0001; tick(); idle();
    req_valid = 1; req_level = 6; rti_valid = 1; rti_level = 4'b1011;
    tick(); idle();
    check("R9 level", cur_level, 3);
    check("R9 trap", trap_active, 1);
    rti_valid = 1; rti_level = 4'b0100; tick(); idle();
    check("R9 clear trap", trap_active, 0);
    check("R9 level2", cur_level, 4);

    // R6: trap entry beats a restore with trap 0
    trap_enter = 1; rti_valid = 1; rti_level = 4'b0110; tick(); idle();
    check("R6 trap over restore", trap_active, 1);
    check("R9 level3", cur_level, 6);

    // R5: level holds with no event
    tick();
    check("R5 hold", cur_level, 6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule